// File: doc/BRIEF.md
# Clause 22 Management Interface Master

This block lets software run single Clause 22 management transactions on an external MDC/MDIO pair, to reach PHYs and switch chips. It has a small 32-bit register port: one address bus, a write-data bus, a write strobe and a read-data bus that answers in the same cycle. Software places the target PHY address and register number in a packed address word. For a write it also places the payload in the write-data word. It then writes the command word with the launch bit set and the wanted access code, and polls the busy flag in that same word until it drops.

The block divides the system clock down to MDC. It serialises a complete frame, most significant bit first: a run of preamble ones, the start pattern 01, the opcode, the 5-bit PHY address, the 5-bit register number, the turnaround and 16 data bits. It changes MDIO only after MDC falls. On reads it releases MDIO at the turnaround and samples the PHY on each rising MDC edge. The 16 captured bits are stored zero-extended in the read-data word when the frame ends.

Top module: `mdio_mgr`

## Requirements
- R1: After reset every readable word returns 0, MDC is low and the MDIO output enable is low.
- R2: A write of the command word at byte offset 0x50 with bit 8 (launch) set while idle makes busy (bit 16 of that word) read 1 from the next cycle. Bit 8 always reads back as 0.
- R3: Busy stays high for exactly 2*DIV_HALF*(PREAMBLE_BITS+32) system cycles, which is 512 with the defaults, and then clears. While idle, MDC is low and the output enable is low.
- R4: MDC has a period of 2*DIV_HALF system cycles and a 50% duty. It starts low at the frame start and rises DIV_HALF cycles later. The driven MDIO value changes only together with a falling MDC edge.
- R5: Access code 1 (bit 0 of the command word) gives a write frame: PREAMBLE_BITS ones, 01, opcode 01, PHY address, register number, turnaround 10 and the 16 payload bits. The output enable is high for the whole frame.
- R6: Access code 0 gives a read frame with opcode 10. The output enable is high for the preamble, start, opcode and address fields, and low from the turnaround through the last data bit.
- R7: On a read, the bit on MDIO is sampled at each rising MDC edge of the 16 data bits, MSB first. The result appears zero-extended in the read-data word (offset 0x4C) only once busy has cleared, and the old value stays there during the frame.
- R8: A command write with launch set while busy has no effect. The running frame, its length and the stored access code are unchanged, and no second frame follows.
- R9: The address word (offset 0x44, PHY in bits 15:8, register in bits 7:0) and the write-data word (offset 0x48, low 16 bits kept) may be rewritten at any time and read back zero-extended. They are sampled only at a frame start.
- R10: A command write with bit 8 clear starts nothing.
- R11: Only address bits 12:8 and 4:0 reach the wire, as PHY address and register number.
- R12: The command word reads back the last accepted access code in bit 0 and the busy state in bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
A PHY model on the wire decodes every frame and compares it with the frame the driver expected. It answers reads with 0x8001, 0xFFFF and 0x0000. The three answers differ in their end bits and in fill, so a bit-order error, a lost or shifted capture bit and a stale read-data word can each be told apart. Write and read frames are run with full-ones address bytes and with small ones, which shows whether the field truncation and the opcode/turnaround choice are right. A launch issued mid-frame, together with new address and payload values, shows whether a second frame appears, whether the running frame is corrupted, or whether busy is stretched. A command write with no launch bit must leave the bus silent.

// File: rtl/mdio_mgr_pkg.sv
package mdio_mgr_pkg;
   localparam logic [7:0] OFS_ADDR  = 8'h44;
   localparam logic [7:0] OFS_WDATA = 8'h48;
   localparam logic [7:0] OFS_RDATA = 8'h4C;
   localparam logic [7:0] OFS_CMD   = 8'h50;
   localparam int BIT_BUSY = 16;
   localparam int BIT_GO   = 8;
   localparam int BIT_CODE = 0;
   localparam int C22_DATA_W = 16;

   typedef enum logic {ACC_READ = 1'b0, ACC_WRITE = 1'b1} acc_e;

   typedef struct packed {
      logic [4:0]            phy;
      logic [4:0]            regn;
      acc_e                  acc;
      logic [C22_DATA_W-1:0] wdata;
   } req_t;
endpackage

// File: rtl/mdio_mgr_clkdiv.sv
module mdio_mgr_clkdiv #(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise,
   output logic fall
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap = (cnt == CW'(HALF - 1));
   assign rise = run & wrap & ~mdc;
   assign fall = run & wrap & mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_mgr_frame.sv
module mdio_mgr_frame
   import mdio_mgr_pkg::*;
#(
   parameter int PREAMBLE_BITS = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  req_t                  req,
   input  logic                  rise,
   input  logic                  fall,
   input  logic                  mdio_i,
   output logic                  active,
   output logic                  mdio_o,
   output logic                  mdio_oe,
   output logic                  rd_load,
   output logic [C22_DATA_W-1:0] rd_val
);
   localparam int FRAME_BITS = PREAMBLE_BITS + 32;
   localparam int IW         = $clog2(FRAME_BITS);
   localparam int REL_IDX    = PREAMBLE_BITS + 14;
   localparam int DATA_IDX   = PREAMBLE_BITS + 16;
   localparam int LAST_IDX   = FRAME_BITS - 1;

   logic [FRAME_BITS-1:0] sh;
   logic [IW-1:0]         idx;
   logic                  is_rd;
   logic [C22_DATA_W-1:0] cap;
   logic                  last_bit;
   logic [1:0]            op_f;
   logic [1:0]            ta_f;
   logic [C22_DATA_W-1:0] dat_f;

   assign op_f  = (req.acc == ACC_READ) ? 2'b10 : 2'b01;
   assign ta_f  = (req.acc == ACC_READ) ? 2'b11 : 2'b10;
   assign dat_f = (req.acc == ACC_READ) ? '0 : req.wdata;

   assign last_bit = (idx == IW'(LAST_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         idx    <= '0;
         is_rd  <= 1'b0;
         cap    <= '0;
         active <= 1'b0;
      end else if (start) begin
         sh     <= {{PREAMBLE_BITS{1'b1}}, 2'b01, op_f, req.phy, req.regn, ta_f, dat_f};
         idx    <= '0;
         is_rd  <= (req.acc == ACC_READ);
         cap    <= '0;
         active <= 1'b1;
      end else if (active) begin
         if (rise && is_rd && (idx >= IW'(DATA_IDX)))
            cap <= {cap[C22_DATA_W-2:0], mdio_i};
         if (fall) begin
            if (last_bit) begin
               active <= 1'b0;
            end else begin
               idx <= idx + 1'b1;
               sh  <= {sh[FRAME_BITS-2:0], 1'b0};
            end
         end
      end
   end

   assign mdio_o  = sh[FRAME_BITS-1];
   assign mdio_oe = active & ~(is_rd & (idx >= IW'(REL_IDX)));
   assign rd_load = active & fall & last_bit & is_rd;
   assign rd_val  = cap;
endmodule

// File: rtl/mdio_mgr_regs.sv
module mdio_mgr_regs
   import mdio_mgr_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [7:0]            bus_addr,
   input  logic [31:0]           bus_wdata,
   input  logic                  bus_we,
   input  logic                  busy,
   input  logic                  rd_load,
   input  logic [C22_DATA_W-1:0] rd_val,
   output logic [31:0]           bus_rdata,
   output logic                  start,
   output req_t                  req
);
   logic [15:0]           addr_q;
   logic [C22_DATA_W-1:0] wd_q;
   logic [C22_DATA_W-1:0] rd_q;
   logic                  code_q;
   logic                  cmd_hit;
   logic                  unused_hi;

   assign unused_hi = ^bus_wdata[31:16];
   assign cmd_hit   = bus_we && (bus_addr == OFS_CMD);
   assign start     = cmd_hit && bus_wdata[BIT_GO] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         wd_q   <= '0;
         rd_q   <= '0;
         code_q <= 1'b0;
      end else begin
         if (bus_we && (bus_addr == OFS_ADDR))  addr_q <= bus_wdata[15:0];
         if (bus_we && (bus_addr == OFS_WDATA)) wd_q   <= bus_wdata[C22_DATA_W-1:0];
         if (cmd_hit && !busy)                  code_q <= bus_wdata[BIT_CODE];
         if (rd_load)                           rd_q   <= rd_val;
      end
   end

   assign req.phy   = addr_q[12:8];
   assign req.regn  = addr_q[4:0];
   assign req.acc   = acc_e'(bus_wdata[BIT_CODE]);
   assign req.wdata = wd_q;

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFS_ADDR:  bus_rdata = {16'h0, addr_q};
         OFS_WDATA: bus_rdata = {{(32-C22_DATA_W){1'b0}}, wd_q};
         OFS_RDATA: bus_rdata = {{(32-C22_DATA_W){1'b0}}, rd_q};
         OFS_CMD:   bus_rdata = {15'h0, busy, 7'h0, 1'b0, 7'h0, code_q};
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mdio_mgr.sv
module mdio_mgr
   import mdio_mgr_pkg::*;
#(
   parameter int DIV_HALF      = 4,
   parameter int PREAMBLE_BITS = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   input  logic        bus_we,
   output logic [31:0] bus_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   if (DIV_HALF < 2) begin : g_bad_div
      $error("DIV_HALF must be 2 or more");
   end
   if (PREAMBLE_BITS < 1 || PREAMBLE_BITS > 32) begin : g_bad_pre
      $error("PREAMBLE_BITS must lie in 1..32");
   end

   logic                  busy;
   logic                  start;
   req_t                  req;
   logic                  rise;
   logic                  fall;
   logic                  rd_load;
   logic [C22_DATA_W-1:0] rd_val;

   mdio_mgr_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .busy      (busy),
      .rd_load   (rd_load),
      .rd_val    (rd_val),
      .bus_rdata (bus_rdata),
      .start     (start),
      .req       (req)
   );

   mdio_mgr_clkdiv #(.HALF(DIV_HALF)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .mdc   (mdc),
      .rise  (rise),
      .fall  (fall)
   );

   mdio_mgr_frame #(.PREAMBLE_BITS(PREAMBLE_BITS)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .req     (req),
      .rise    (rise),
      .fall    (fall),
      .mdio_i  (mdio_i),
      .active  (busy),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .rd_load (rd_load),
      .rd_val  (rd_val)
   );
endmodule

// File: rtl/mdio_mgr_chk.sv
module mdio_mgr_chk #(
   parameter int DIV_HALF      = 4,
   parameter int PREAMBLE_BITS = 32
) (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] bus_addr,
   input logic       bus_we,
   input logic       go_bit,
   input logic       rd_go,
   input logic       rd_busy,
   input logic       busy,
   input logic       mdc,
   input logic       mdio_o,
   input logic       mdio_oe
);
   localparam int FRAME_CYC = 2 * DIV_HALF * (PREAMBLE_BITS + 32);
   localparam logic [7:0] CMD_OFS = 8'h50;

   int fcnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    fcnt <= 0;
      else if (busy) fcnt <= fcnt + 1;
      else           fcnt <= 0;
   end

   AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bus_we && bus_addr == CMD_OFS && go_bit)); // R2
   AST_GO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == CMD_OFS && go_bit && !busy) |=> busy); // R2
   AST_GO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == CMD_OFS) |-> !rd_go); // R2
   AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (fcnt == FRAME_CYC)); // R3
   AST_FRAME_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (fcnt < FRAME_CYC)); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe)); // R3
   AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_oe && $past(mdio_oe) && mdio_o != $past(mdio_o)) |-> $fell(mdc)); // R4
   AST_BUSY_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == CMD_OFS) |-> (rd_busy == busy)); // R12
endmodule

bind mdio_mgr mdio_mgr_chk #(.DIV_HALF(DIV_HALF), .PREAMBLE_BITS(PREAMBLE_BITS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_addr(bus_addr),
   .bus_we  (bus_we),
   .go_bit  (bus_wdata[8]),
   .rd_go   (bus_rdata[8]),
   .rd_busy (bus_rdata[16]),
   .busy    (busy),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe)
);

// File: tb/mdio_mgr_test.sv
module mdio_mgr_test;
   localparam int HALF  = 4;
   localparam int FBITS = 64;
   localparam int FCYC  = 2 * HALF * FBITS;
   localparam logic [63:0] RD_MASK = ~64'h0 << 18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        mdio_i = 1'b1;
   wire  [31:0] bus_rdata;
   wire         mdc, mdio_o, mdio_oe;

   always #4 clk = ~clk;

   mdio_mgr #(.DIV_HALF(HALF), .PREAMBLE_BITS(32)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   typedef struct {
      logic [63:0] bits;
      bit          rd;
      logic [15:0] rsp;
      string       tag;
   } item_t;
   item_t exp_q[$];

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   // PHY model / monitor: decodes each frame on the wire and pops the scoreboard
   int          k = 0;
   bit          have = 0;
   item_t       cur;
   logic [63:0] seen = '0;
   logic [63:0] oe_seen = '0;

   always @(posedge mdc) begin
      if (k == 0) begin
         have = (exp_q.size() > 0);
         if (have) cur = exp_q[0];
      end
      seen[63-k]    = mdio_o;
      oe_seen[63-k] = mdio_oe;
      k++;
      if (k == FBITS) begin
         k = 0;
         if (!have) begin
            chk(0, "R8 unexpected frame on wire", seen, 64'h0);
         end else begin
            void'(exp_q.pop_front());
            if (cur.rd) begin
               chk((seen & RD_MASK) == (cur.bits & RD_MASK), {cur.tag, " R6 read header"}, seen, cur.bits);
               chk(oe_seen == RD_MASK, {cur.tag, " R6 read release window"}, oe_seen, RD_MASK);
            end else begin
               chk(seen == cur.bits, {cur.tag, " R5 write frame"}, seen, cur.bits);
               chk(oe_seen == ~64'h0, {cur.tag, " R5 write enable"}, oe_seen, ~64'h0);
            end
         end
      end
   end

   always @(negedge mdc) begin
      if (have && cur.rd && k >= 47)
         mdio_i = (k == 47) ? 1'b0 : cur.rsp[63-k];
      else
         mdio_i = 1'b1;
   end

   task automatic bwr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic brd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic launch(input logic [7:0] phy, input logic [7:0] rg, input bit rd,
                         input logic [15:0] data, input logic [15:0] rsp, input string tag);
      item_t it;
      it.bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy[4:0], rg[4:0],
                 (rd ? 2'b11 : 2'b10), (rd ? 16'h0 : data)};
      it.rd = rd; it.rsp = rsp; it.tag = tag;
      exp_q.push_back(it);
      bwr(8'h44, {16'h0, phy, rg});
      if (!rd) bwr(8'h48, {16'hA5A5, data});
      bwr(8'h50, rd ? 32'h0000_0100 : 32'h0000_0101);
   endtask

   // counts busy cycles from now and compares MDC with the expected square wave
   task automatic wait_frame(output int cyc, output int bad);
      logic [31:0] r;
      cyc = 0; bad = 0;
      brd(8'h50, r);
      while (r[16] && cyc < 2 * FCYC) begin
         if (mdc !== ((cyc / HALF) % 2 == 1)) bad++;
         cyc++;
         @(negedge clk);
         brd(8'h50, r);
      end
   endtask

   task automatic wait_idle(output int cyc);
      logic [31:0] r;
      cyc = 0;
      brd(8'h50, r);
      while (r[16] && cyc < 2 * FCYC) begin
         cyc++;
         @(negedge clk);
         brd(8'h50, r);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog expired", 64'h0, 64'h0);
      summary();
   end

   initial begin
      logic [31:0] r;
      int cyc, bad, pre;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      brd(8'h44, r); chk(r == 0, "R1 address word after reset", r, 0);
      brd(8'h48, r); chk(r == 0, "R1 write word after reset", r, 0);
      brd(8'h4C, r); chk(r == 0, "R1 read word after reset", r, 0);
      brd(8'h50, r); chk(r == 0, "R1 command word after reset", r, 0);
      chk(mdc == 0 && mdio_oe == 0, "R1 pins idle", {mdc, mdio_oe}, 0);

      // write frame
      launch(8'h05, 8'h1A, 0, 16'hBEEF, 16'h0, "T2");
      brd(8'h50, r);
      chk(r == 32'h0001_0001, "R2 R12 busy set, launch reads 0, code 1", r, 32'h0001_0001);
      wait_frame(cyc, bad);
      chk(cyc == FCYC, "R3 write busy length", cyc, FCYC);
      chk(bad == 0, "R4 MDC waveform in write", bad, 0);
      brd(8'h48, r); chk(r == 32'h0000_BEEF, "R9 write word readback", r, 32'h0000_BEEF);

      // read frame with wide address bytes
      launch(8'hFF, 8'hE3, 1, 16'h0, 16'h8001, "T3 R11 truncation");
      brd(8'h44, r); chk(r == 32'h0000_FFE3, "R9 address readback", r, 32'h0000_FFE3);
      brd(8'h50, r); chk(r == 32'h0001_0000, "R12 code 0 with busy", r, 32'h0001_0000);
      repeat (300) @(negedge clk);
      brd(8'h4C, r); chk(r == 0, "R7 read word unchanged mid-frame", r, 0);
      wait_idle(cyc);
      brd(8'h4C, r); chk(r == 32'h0000_8001, "R7 captured 0x8001", r, 32'h0000_8001);

      // all-ones answer
      launch(8'h00, 8'h1F, 1, 16'h0, 16'hFFFF, "T4");
      wait_frame(cyc, bad);
      chk(cyc == FCYC, "R3 read busy length", cyc, FCYC);
      chk(bad == 0, "R4 MDC waveform in read", bad, 0);
      brd(8'h4C, r); chk(r == 32'h0000_FFFF, "R7 zero-extended 0xFFFF", r, 32'h0000_FFFF);

      // all-zero answer after all-ones
      launch(8'h11, 8'h02, 1, 16'h0, 16'h0000, "T5");
      wait_idle(cyc);
      brd(8'h4C, r); chk(r == 0, "R7 captured 0x0000", r, 0);

      // launch while busy, with new address and payload
      launch(8'h12, 8'h07, 0, 16'h5A5A, 16'h0, "T6 R8 R9 held fields");
      pre = 3;
      repeat (40) @(negedge clk);
      pre += 40;
      bwr(8'h44, 32'h0000_0303);
      bwr(8'h48, 32'h0000_FFFF);
      bwr(8'h50, 32'h0000_0100);
      pre += 3;
      brd(8'h50, r); chk(r == 32'h0001_0001, "R8 code kept after ignored launch", r, 32'h0001_0001);
      wait_idle(cyc);
      chk(cyc + pre == FCYC, "R8 busy length unchanged", cyc + pre, FCYC);
      repeat (2 * FCYC) @(negedge clk);
      chk(exp_q.size() == 0, "R8 no pending frame", exp_q.size(), 0);
      brd(8'h44, r); chk(r == 32'h0000_0303, "R9 address rewrite kept", r, 32'h0000_0303);

      // command write without launch
      bwr(8'h50, 32'h0000_0001);
      bad = 0;
      for (int i = 0; i < 50; i++) begin
         brd(8'h50, r);
         if (r[16] || mdc || mdio_oe) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R10 no frame without launch", bad, 0);
      brd(8'h50, r); chk(r == 32'h0000_0001, "R12 code stored without launch", r, 1);

      chk(exp_q.size() == 0, "R5 every expected frame seen", exp_q.size(), 0);
      summary();
   end
endmodule